// File: doc/BRIEF.md
# Parallel Flash Command Sequence Decoder

This block sits on the write side of a parallel NOR flash interface. It watches each write bus cycle, which is marked by a one-cycle write strobe, and follows the multi-cycle unlock sequences that select flash operations. These operations are erase at chip, plane or sector scope, word program, suspend and resume, identifier mode, query mode, configuration writes and sector protection. When a sequence completes, the block raises a one-cycle command pulse. The pulse carries an operation code and the address and data of the final write. The block also keeps the mode flags, the configuration register and a sticky per-sector hardlock map.

Only part of each write is decoded. The low data byte is compared, and the upper data byte is ignored. Address bits 10:0 are compared, and bit 11 and everything above it are ignored. The full address and data word are still captured for the operation that completes.

A write that does not fit the current sequence drops the decoder back to idle without a pulse. The same write is then treated as a possible first cycle.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, all of the following are 0:
  - `cmdValid` and `rejected`
  - `idMode`, `cfiMode` and `suspended`
  - `cfgReg`
  - every `hardLock` bit
- R2: Data bits 15:8 and address bits 21:11 never affect decoding. An unlock address may therefore be written as x555 or xAAA/x2AA with any upper bits.
- R3: Word program (`cmdOp`=4) has four cycles:
  - 0xAA to 0x555
  - 0x55 to 0xAAA
  - 0xA0 to 0x555
  - any address and data word

  The pulse is high in the cycle after the clock edge that takes the final write. `cmdAddr`/`cmdData` then hold that write's full address and data.
- R4: The erase operations share a prefix: unlock, then 0x80 to 0x555, then unlock again. The sixth write selects the operation:
  - 0x10 to 0x555 gives chip erase (op 1).
  - 0x20 to any address gives plane erase (op 2). The plane is `cmdAddr[21:20]`.
  - 0x30 to any address gives sector erase (op 3).
- R5: A single write of 0xB0 to any address gives suspend (op 5) and sets `suspended`. A single write of 0x30 gives resume (op 6) and clears it.
- R6: Identifier entry sets `idMode`. It is unlock, then 0x90 to 0x555 (op 7). Identifier exit clears `idMode` and `cfiMode` (op 8). There are two forms of exit:
  - a single write of 0xF0 to any address
  - unlock, then 0xF0 to 0x555
- R7: A single write of 0x98 to address 0x055 gives a query (op 9) and sets `cfiMode`. The same write to any other address does nothing.
- R8: A configuration write is unlock, then 0xE0 to 0x555, then a fourth write whose low byte is 0x00 or 0x01 (op 10). That write loads `cfgReg`. Any other low byte aborts without a pulse and leaves `cfgReg` unchanged.
- R9: The protection operations use the R4 prefix. The sixth write targets the sector at `wrAddr[21:18]`:
  - 0x40 gives softlock (op 11).
  - 0x60 gives hardlock (op 13) and sets that sector's `hardLock` bit.
  - 0x70 gives unlock (op 12), which never clears a hardlock bit. Only reset clears hardlock bits.
- R10: A program or sector erase aimed at a hardlocked sector produces no `cmdValid`. It pulses `rejected` instead. The same operation on an unlocked sector, and chip erase, are unaffected.
- R11: A write that does not match the expected next cycle returns the decoder to idle without a pulse. That write is decoded again as a first cycle, so a single-cycle command it carries still fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | One bus write cycle per high clock |
| wrAddr | input | 22 | Word address of the write |
| wrData | input | 16 | Data word of the write |
| cmdValid | output | 1 | One-cycle pulse for a completed command |
| cmdOp | output | 4 | Operation code of the last completed sequence |
| cmdAddr | output | 22 | Address of the final write of that sequence |
| cmdData | output | 16 | Data of the final write of that sequence |
| rejected | output | 1 | One-cycle pulse for an operation blocked by hardlock |
| idMode | output | 1 | Identifier mode active |
| cfiMode | output | 1 | Query mode active |
| suspended | output | 1 | Erase/program suspended |
| cfgReg | output | 2 | Configuration register |
| hardLock | output | 16 | Per-sector hardlock bits |

## Verification
The embedded assertions check the following on every cycle:
- A pulse never appears together with a rejection.
- A rejection only ever concerns program or sector erase.
- Hardlock bits only ever gain ones.
- The configuration register changes only with a configuration pulse and never leaves its two legal values.
- The decoder returns to idle after every command.

Only the bench's scenarios can show the rest:
- Which opcode a given write history produces.
- That upper address and data bits are really ignored.
- That an aborted sequence re-decodes its last write.
- That suppression hits exactly the locked sectors.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  typedef enum logic [3:0] {
    OP_NONE        = 4'd0,
    OP_CHIP_ERASE  = 4'd1,
    OP_PLANE_ERASE = 4'd2,
    OP_SECT_ERASE  = 4'd3,
    OP_PROGRAM     = 4'd4,
    OP_SUSPEND     = 4'd5,
    OP_RESUME      = 4'd6,
    OP_ID_ENTER    = 4'd7,
    OP_ID_EXIT     = 4'd8,
    OP_CFI         = 4'd9,
    OP_CFG_WRITE   = 4'd10,
    OP_SOFTLOCK    = 4'd11,
    OP_UNLOCK      = 4'd12,
    OP_HARDLOCK    = 4'd13
  } opCode_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_U1, ST_U2, ST_PROG, ST_CFG, ST_E3, ST_E4, ST_E5
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic    fire;
    opCode_t op;
  } ctrlStrb_t;

  localparam int CMP_ADDR_W = 11;   // bits 10:0 take part in matching
  localparam logic [CMP_ADDR_W-1:0] KEY_ADDR_A = 11'h555;
  localparam logic [CMP_ADDR_W-1:0] KEY_ADDR_B = 11'h2AA;
  localparam logic [CMP_ADDR_W-1:0] QUERY_ADDR = 11'h055;

endpackage

// File: rtl/fcd_ctrl.sv
module fcd_ctrl
  import fcd_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [CMP_ADDR_W-1:0] addrLo,
  input  logic [7:0]            dataLo,
  output ctrlStrb_t             strb
);

  seqState_t state, stateNext;

  logic      atKeyA, atKeyB;
  seqState_t idleNext;
  logic      idleFire;
  opCode_t   idleOp;

  assign atKeyA = (addrLo == KEY_ADDR_A);
  assign atKeyB = (addrLo == KEY_ADDR_B);

  // first-cycle decode, also used to re-examine a mismatching write
  always_comb begin
    idleNext = ST_IDLE;
    idleFire = 1'b0;
    idleOp   = OP_NONE;
    if (dataLo == 8'hAA && atKeyA) begin
      idleNext = ST_U1;
    end else begin
      unique case (dataLo)
        8'hB0: begin idleFire = 1'b1; idleOp = OP_SUSPEND; end
        8'h30: begin idleFire = 1'b1; idleOp = OP_RESUME;  end
        8'hF0: begin idleFire = 1'b1; idleOp = OP_ID_EXIT; end
        8'h98: if (addrLo == QUERY_ADDR) begin idleFire = 1'b1; idleOp = OP_CFI; end
        default: ;
      endcase
    end
  end

  always_comb begin
    logic useIdle;
    logic seqFire;
    opCode_t seqOp;
    useIdle   = 1'b0;
    seqFire   = 1'b0;
    seqOp     = OP_NONE;
    stateNext = ST_IDLE;
    unique case (state)
      ST_IDLE: useIdle = 1'b1;
      ST_U1: if (dataLo == 8'h55 && atKeyB) stateNext = ST_U2; else useIdle = 1'b1;
      ST_U2: begin
        if (atKeyA && dataLo == 8'hA0)      stateNext = ST_PROG;
        else if (atKeyA && dataLo == 8'h80) stateNext = ST_E3;
        else if (atKeyA && dataLo == 8'hE0) stateNext = ST_CFG;
        else if (atKeyA && dataLo == 8'h90) begin seqFire = 1'b1; seqOp = OP_ID_ENTER; end
        else if (atKeyA && dataLo == 8'hF0) begin seqFire = 1'b1; seqOp = OP_ID_EXIT; end
        else useIdle = 1'b1;
      end
      ST_PROG: begin seqFire = 1'b1; seqOp = OP_PROGRAM; end
      ST_CFG: begin
        if (dataLo == 8'h00 || dataLo == 8'h01) begin seqFire = 1'b1; seqOp = OP_CFG_WRITE; end
        else useIdle = 1'b1;
      end
      ST_E3: if (dataLo == 8'hAA && atKeyA) stateNext = ST_E4; else useIdle = 1'b1;
      ST_E4: if (dataLo == 8'h55 && atKeyB) stateNext = ST_E5; else useIdle = 1'b1;
      ST_E5: begin
        seqFire = 1'b1;
        unique case (dataLo)
          8'h10: if (atKeyA) seqOp = OP_CHIP_ERASE; else seqFire = 1'b0;
          8'h20: seqOp = OP_PLANE_ERASE;
          8'h30: seqOp = OP_SECT_ERASE;
          8'h40: seqOp = OP_SOFTLOCK;
          8'h60: seqOp = OP_HARDLOCK;
          8'h70: seqOp = OP_UNLOCK;
          default: seqFire = 1'b0;
        endcase
        useIdle = !seqFire;
      end
      default: useIdle = 1'b1;
    endcase

    strb.fire = 1'b0;
    strb.op   = OP_NONE;
    if (!wrEn) begin
      stateNext = state;
    end else if (useIdle) begin
      stateNext = idleNext;
      strb.fire = idleFire;
      strb.op   = idleOp;
    end else begin
      strb.fire = seqFire;
      strb.op   = seqOp;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  AST_FIRE_RETURNS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    strb.fire |=> state == ST_IDLE);                                   // R11
  AST_PROG_DATA_FIRES: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PROG && wrEn) |-> (strb.fire && strb.op == OP_PROGRAM)); // R3

endmodule

// File: rtl/fcd_dpath.sv
module fcd_dpath
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 16,
  parameter int SECT_W = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrb_t             strb,
  input  logic [ADDR_W-1:0]     wrAddr,
  input  logic [DATA_W-1:0]     wrData,
  output logic                  cmdValid,
  output opCode_t               cmdOp,
  output logic [ADDR_W-1:0]     cmdAddr,
  output logic [DATA_W-1:0]     cmdData,
  output logic                  rejected,
  output logic                  idMode,
  output logic                  cfiMode,
  output logic                  suspended,
  output logic [1:0]            cfgReg,
  output logic [(1<<SECT_W)-1:0] hardLock
);

  localparam int NUM_SECT = 1 << SECT_W;

  logic [SECT_W-1:0]   sectIdx;
  logic                guarded, blocked, accept;
  logic [NUM_SECT-1:0] setLock;

  assign sectIdx = wrAddr[ADDR_W-1 -: SECT_W];
  assign guarded = (strb.op == OP_PROGRAM) || (strb.op == OP_SECT_ERASE);
  assign blocked = strb.fire && guarded && hardLock[sectIdx];
  assign accept  = strb.fire && !blocked;

  for (genvar gi = 0; gi < NUM_SECT; gi++) begin : g_lock
    assign setLock[gi] = accept && (strb.op == OP_HARDLOCK) && (sectIdx == SECT_W'(gi));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdValid  <= 1'b0;
      rejected  <= 1'b0;
      cmdOp     <= OP_NONE;
      cmdAddr   <= '0;
      cmdData   <= '0;
      idMode    <= 1'b0;
      cfiMode   <= 1'b0;
      suspended <= 1'b0;
      cfgReg    <= 2'b00;
      hardLock  <= '0;
    end else begin
      cmdValid <= accept;
      rejected <= blocked;
      hardLock <= hardLock | setLock;
      if (strb.fire) begin
        cmdOp   <= strb.op;
        cmdAddr <= wrAddr;
        cmdData <= wrData;
      end
      if (accept) begin
        unique case (strb.op)
          OP_SUSPEND:   suspended <= 1'b1;
          OP_RESUME:    suspended <= 1'b0;
          OP_ID_ENTER:  idMode    <= 1'b1;
          OP_ID_EXIT:   begin idMode <= 1'b0; cfiMode <= 1'b0; end
          OP_CFI:       cfiMode   <= 1'b1;
          OP_CFG_WRITE: cfgReg    <= wrData[1:0];
          default: ;
        endcase
      end
    end
  end

  AST_PULSE_OR_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdValid && rejected));                                          // R10
  AST_REJECT_GUARDED_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    rejected |-> (cmdOp == OP_PROGRAM || cmdOp == OP_SECT_ERASE));     // R10
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (hardLock & $past(hardLock)) == $past(hardLock));                  // R9
  AST_CFG_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    !cfgReg[1]);                                                       // R8
  AST_CFG_ONLY_ON_CMD: assert property (@(posedge clk) disable iff (!rstN)
    (cfgReg != $past(cfgReg)) |-> (cmdValid && cmdOp == OP_CFG_WRITE)); // R8

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 16,
  parameter int SECT_W = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    wrEn,
  input  logic [ADDR_W-1:0]       wrAddr,
  input  logic [DATA_W-1:0]       wrData,
  output logic                    cmdValid,
  output logic [3:0]              cmdOp,
  output logic [ADDR_W-1:0]       cmdAddr,
  output logic [DATA_W-1:0]       cmdData,
  output logic                    rejected,
  output logic                    idMode,
  output logic                    cfiMode,
  output logic                    suspended,
  output logic [1:0]              cfgReg,
  output logic [(1<<SECT_W)-1:0]  hardLock
);

  ctrlStrb_t strb;
  opCode_t   opReg;

  fcd_ctrl i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .addrLo (wrAddr[CMP_ADDR_W-1:0]),
    .dataLo (wrData[7:0]),
    .strb   (strb)
  );

  fcd_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SECT_W(SECT_W)) i_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .cmdValid  (cmdValid),
    .cmdOp     (opReg),
    .cmdAddr   (cmdAddr),
    .cmdData   (cmdData),
    .rejected  (rejected),
    .idMode    (idMode),
    .cfiMode   (cfiMode),
    .suspended (suspended),
    .cfgReg    (cfgReg),
    .hardLock  (hardLock)
  );

  assign cmdOp = opReg;

  AST_PULSE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid || rejected) |-> $past(wrEn));                           // R3

endmodule

// File: tb/test_flash_cmd_decoder.sv
module test_flash_cmd_decoder;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        wrEn;
  logic [21:0] wrAddr;
  logic [15:0] wrData;
  logic        cmdValid, rejected, idMode, cfiMode, suspended;
  logic [3:0]  cmdOp;
  logic [21:0] cmdAddr;
  logic [15:0] cmdData;
  logic [1:0]  cfgReg;
  logic [15:0] hardLock;

  int nChk = 0;
  int nErr = 0;

  logic        sV, sR;
  logic [3:0]  sOp;
  logic [21:0] sA;
  logic [15:0] sD;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_decoder i_flash_cmd_decoder (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdAddr(cmdAddr), .cmdData(cmdData),
    .rejected(rejected), .idMode(idMode), .cfiMode(cfiMode), .suspended(suspended),
    .cfgReg(cfgReg), .hardLock(hardLock)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one bus write, starting at a falling edge; outputs sampled one edge later
  task automatic wr(input logic [21:0] a, input logic [15:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    sV = cmdValid; sR = rejected; sOp = cmdOp; sA = cmdAddr; sD = cmdData;
    wrEn = 1'b0;
  endtask

  task automatic unlock();
    wr(22'h000555, 16'h00AA);
    wr(22'h000AAA, 16'h0055);
  endtask

  task automatic prefix6();
    unlock();
    wr(22'h000555, 16'h0080);
    unlock();
  endtask

  task automatic expectCmd(input string req, input logic v, input logic [3:0] op);
    chk(req, {63'd0, sV}, {63'd0, v});
    if (v) chk(req, {60'd0, sOp}, {60'd0, op});
  endtask

  function automatic logic [3:0] expSingle(input logic [7:0] b, input logic atQuery);
    case (b)
      8'hB0: return 4'd5;
      8'h30: return 4'd6;
      8'hF0: return 4'd8;
      8'h98: return atQuery ? 4'd9 : 4'd0;
      default: return 4'd0;
    endcase
  endfunction

  function automatic logic [3:0] expThird(input logic [7:0] b);
    case (b)
      8'h90: return 4'd7;
      8'hF0: return 4'd8;
      8'hB0: return 4'd5;
      8'h30: return 4'd6;
      default: return 4'd0;
    endcase
  endfunction

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nChk++; nErr++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] lockMask;
    rstN = 1'b0; wrEn = 1'b0; wrAddr = '0; wrData = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 valid", {63'd0, cmdValid}, 64'd0);
    chk("R1 rejected", {63'd0, rejected}, 64'd0);
    chk("R1 flags", {61'd0, idMode, cfiMode, suspended}, 64'd0);
    chk("R1 cfg", {62'd0, cfgReg}, 64'd0);
    chk("R1 locks", {48'd0, hardLock}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 R3 program with junk in ignored bits and the 2AA alias
    wr(22'h2A5D55, 16'h7FAA);
    wr(22'h1232AA, 16'hC355);
    wr(22'h000555, 16'hFFA0);
    expectCmd("R3 no early pulse", 1'b0, 4'd0);
    wr(22'h3C1234, 16'hBEEF);
    expectCmd("R2 R3 program", 1'b1, 4'd4);
    chk("R3 addr", {42'd0, sA}, {42'd0, 22'h3C1234});
    chk("R3 data", {48'd0, sD}, {48'd0, 16'hBEEF});
    @(negedge clk);
    chk("R3 one-cycle pulse", {63'd0, cmdValid}, 64'd0);

    // R4 erase variants
    prefix6(); wr(22'h000555, 16'h0010);
    expectCmd("R4 chip", 1'b1, 4'd1);
    prefix6(); wr(22'h200123, 16'h0020);
    expectCmd("R4 plane", 1'b1, 4'd2);
    chk("R4 plane index", {62'd0, sA[21:20]}, 64'd2);
    prefix6(); wr(22'h0C4567, 16'h0030);
    expectCmd("R4 sector", 1'b1, 4'd3);
    chk("R4 sector addr", {42'd0, sA}, {42'd0, 22'h0C4567});
    prefix6(); wr(22'h000556, 16'h0010);
    expectCmd("R4 chip needs 555", 1'b0, 4'd0);

    // R5 suspend / resume
    wr(22'h012345, 16'h00B0);
    expectCmd("R5 suspend", 1'b1, 4'd5);
    chk("R5 suspended set", {63'd0, suspended}, 64'd1);
    wr(22'h3FFFFF, 16'hAB30);
    expectCmd("R5 resume", 1'b1, 4'd6);
    chk("R5 suspended clear", {63'd0, suspended}, 64'd0);

    // R6 identifier mode, both exits
    unlock(); wr(22'h000555, 16'h0090);
    expectCmd("R6 enter", 1'b1, 4'd7);
    chk("R6 idMode set", {63'd0, idMode}, 64'd1);
    wr(22'h001000, 16'h00F0);
    expectCmd("R6 short exit", 1'b1, 4'd8);
    chk("R6 idMode clear", {63'd0, idMode}, 64'd0);
    unlock(); wr(22'h000555, 16'h0090);
    unlock(); wr(22'h000555, 16'h00F0);
    expectCmd("R6 long exit", 1'b1, 4'd8);
    chk("R6 idMode clear long", {63'd0, idMode}, 64'd0);

    // R7 query
    wr(22'h000056, 16'h0098);
    expectCmd("R7 wrong addr", 1'b0, 4'd0);
    chk("R7 cfiMode untouched", {63'd0, cfiMode}, 64'd0);
    wr(22'h000055, 16'h0098);
    expectCmd("R7 query", 1'b1, 4'd9);
    chk("R7 cfiMode set", {63'd0, cfiMode}, 64'd1);
    wr(22'h000000, 16'h00F0);
    chk("R7 cfiMode cleared by exit", {63'd0, cfiMode}, 64'd0);

    // R8 configuration register
    unlock(); wr(22'h000555, 16'h00E0); wr(22'h000000, 16'h0001);
    expectCmd("R8 cfg write", 1'b1, 4'd10);
    chk("R8 cfg=1", {62'd0, cfgReg}, 64'd1);
    unlock(); wr(22'h000555, 16'h00E0); wr(22'h000000, 16'h0005);
    expectCmd("R8 bad value aborts", 1'b0, 4'd0);
    chk("R8 cfg kept", {62'd0, cfgReg}, 64'd1);
    unlock(); wr(22'h000555, 16'h00E0); wr(22'h000000, 16'hFF00);
    expectCmd("R8 R2 cfg zero", 1'b1, 4'd10);
    chk("R8 cfg=0", {62'd0, cfgReg}, 64'd0);

    // R11 mismatch and re-examination
    wr(22'h000555, 16'h00AA); wr(22'h000123, 16'h00B0);
    expectCmd("R11 reexam suspend", 1'b1, 4'd5);
    wr(22'h000000, 16'h0030);
    unlock(); wr(22'h000555, 16'h0080); wr(22'h000000, 16'h0077);
    expectCmd("R11 abort", 1'b0, 4'd0);
    wr(22'h000555, 16'h0010);
    expectCmd("R11 back to idle", 1'b0, 4'd0);

    // R2 R5 R6 R7 sweep of every single-write low byte
    for (int b = 0; b < 256; b++) begin
      wr(22'h155055, {~b[7:0], b[7:0]});
      expectCmd("R2 R7 single sweep", expSingle(b[7:0], 1'b1) != 0, expSingle(b[7:0], 1'b1));
    end

    // R11 sweep of every third-cycle byte, then a cleanup write
    for (int b = 0; b < 256; b++) begin
      unlock();
      wr(22'h000555, {8'h5A, b[7:0]});
      expectCmd("R11 third sweep", expThird(b[7:0]) != 0, expThird(b[7:0]));
      wr(22'h000000, 16'h0077);
      expectCmd("R11 cleanup", b == 8'hA0, 4'd4);
    end

    // R9 hardlock every third sector
    lockMask = '0;
    for (int s = 0; s < 16; s++) begin
      if (s % 3 == 0) begin
        prefix6(); wr({s[3:0], 18'h00ABC}, 16'h0060);
        expectCmd("R9 hardlock", 1'b1, 4'd13);
        lockMask[s] = 1'b1;
      end
    end
    chk("R9 lock map", {48'd0, hardLock}, {48'd0, lockMask});
    prefix6(); wr(22'h000100, 16'h0070);
    expectCmd("R9 unlock cmd", 1'b1, 4'd12);
    prefix6(); wr(22'h040100, 16'h0040);
    expectCmd("R9 softlock cmd", 1'b1, 4'd11);
    chk("R9 locks unchanged", {48'd0, hardLock}, {48'd0, lockMask});

    // R10 suppression per sector
    for (int s = 0; s < 16; s++) begin
      unlock(); wr(22'h000555, 16'h00A0); wr({s[3:0], 18'h01234}, 16'h5A5A);
      chk("R10 program valid", {63'd0, sV}, {63'd0, !lockMask[s]});
      chk("R10 program rejected", {63'd0, sR}, {63'd0, lockMask[s]});
      prefix6(); wr({s[3:0], 18'h00010}, 16'h0030);
      chk("R10 erase valid", {63'd0, sV}, {63'd0, !lockMask[s]});
      chk("R10 erase rejected", {63'd0, sR}, {63'd0, lockMask[s]});
    end
    prefix6(); wr(22'h000555, 16'h0010);
    expectCmd("R10 chip erase unaffected", 1'b1, 4'd1);
    chk("R10 chip not rejected", {63'd0, sR}, 64'd0);

    // R1 R9 reset clears hardlock
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    chk("R1 R9 locks cleared", {48'd0, hardLock}, 64'd0);
    chk("R1 cfg after reset", {62'd0, cfgReg}, 64'd0);

    summary();
    $finish;
  end

endmodule